// File: doc/BRIEF.md
# Writeback Float Narrower and Slice Scatterer

This block sits on the result writeback path of a register file that stores operands in 4-bit slices. Each 32-bit physical register word holds eight slices, and an operand can occupy any subset of them, possibly spread over two physical registers. A result arrives with a flag that says whether it is a float, a format code for the reduced float width, two 8-bit slice masks and two physical register indices. A float is first narrowed to the selected reduced format. The operand's nibbles are then placed, lowest nibble first, into the slices that the masks select.

The outputs are two data words, each with an 8-bit per-slice write enable, and the two register indices. The register file writes only the enabled slices, so other operands packed into the same words are left intact. Integers go straight to placement and appear one cycle after they are presented. Floats pass through a conversion stage and appear after two cycles.

Top module: `wb_slice_packer`

## Requirements
- R1: Data nibble k (bits 4k+3..4k of the operand after narrowing) is placed in the slice of the k-th set bit of mask0, counted from slice 0 upward. The nibbles that follow are placed in the set bits of mask1 in ascending order. Slice s of a word is bits 4s+3..4s.
- R2: out_we0 and out_we1 equal the mask0 and mask1 of the item being output. Every slice whose enable bit is 0 reads as zero, and both enables are zero whenever out_valid is low.
- R3: An integer presented with in_valid is output with out_valid exactly one cycle later. A float is output exactly two cycles later. Each accepted item gives exactly one out_valid pulse.
- R4: The format codes select a float layout given as total/exponent/mantissa bits: 0=32/8/23, 1=28/7/20, 2=24/6/17, 3=20/5/14, 4=16/5/10, 5=12/4/7, 6=8/3/4. The narrow value is {sign, exponent, mantissa} in its low bits. The exponent is rebiased to a bias of 2^(E-1)-1. The mantissa keeps the top fraction bits with no rounding.
- R5: A finite float whose rebiased exponent is at or above the narrow all-ones exponent becomes infinity with the original sign.
- R6: A denormal or zero input, or a rebiased exponent of 0 or less, becomes zero with the original sign.
- R7: A NaN input stays NaN: the exponent is all ones and the top mantissa bit is forced to 1. Infinity input stays infinity with the same sign.
- R8: If the masks select more than eight slices in total, the slices beyond the eighth nibble are written with zero.
- R9: During and after reset, out_valid is low and both write enables are zero.
- R10: out_preg0 and out_preg1 carry the register indices presented with the item, aligned with its data.
- R11: Integers are placed without any change to their low nibbles; the format code is ignored for them.
- R12: The caller does not present an integer in the cycle that directly follows a float.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Result present this cycle |
| in_is_float | input | 1 | 1 = float, narrow before placement |
| in_fmt | input | 3 | Reduced float format code (R4) |
| in_value | input | 32 | Result value |
| in_mask0 | input | 8 | Slice mask of the first physical register |
| in_mask1 | input | 8 | Slice mask of the second physical register |
| in_preg0 | input | PREG_W | First physical register index |
| in_preg1 | input | PREG_W | Second physical register index |
| out_valid | output | 1 | Writeback item ready |
| out_preg0 | output | PREG_W | First register index |
| out_preg1 | output | PREG_W | Second register index |
| out_word0 | output | 32 | Data for the first register |
| out_we0 | output | 8 | Slice write enables, first register |
| out_word1 | output | 32 | Data for the second register |
| out_we1 | output | 8 | Slice write enables, second register |

## Verification
Integers with full, split and oversubscribed masks show whether nibble order, the carry-over point between the two masks, and the zero fill past eight nibbles are right. Floats in several formats are chosen to sit on the largest finite value, the first overflow, the smallest normal, the first underflow, and a truncation that must not round up. NaN, infinity and signed zero inputs separate the special-value paths. Each output is gathered back from the masked slices and compared with the expected narrow pattern. Mixed integer and float streams check the one-cycle and two-cycle latencies.

// File: rtl/wbsp_pkg.sv
package wbsp_pkg;

    localparam int unsigned WORD_W  = 32;
    localparam int unsigned SLICE_W = 4;
    localparam int unsigned SLICES  = WORD_W / SLICE_W;
    localparam int unsigned RANK_W  = $clog2(2 * SLICES + 1);

    localparam int unsigned SRC_EXP_W  = 8;
    localparam int unsigned SRC_MAN_W  = 23;
    localparam int unsigned SRC_BIAS   = 127;
    localparam int unsigned SRC_EXPMAX = (1 << SRC_EXP_W) - 1;

    typedef enum logic [2:0] {
        FMT_W32 = 3'd0,
        FMT_W28 = 3'd1,
        FMT_W24 = 3'd2,
        FMT_W20 = 3'd3,
        FMT_W16 = 3'd4,
        FMT_W12 = 3'd5,
        FMT_W8  = 3'd6
    } fmt_e;

    typedef struct packed {
        logic [WORD_W-1:0] data;
        logic [SLICES-1:0] mask0;
        logic [SLICES-1:0] mask1;
    } slice_set_t;

    function automatic int unsigned fmt_man_bits(input logic [2:0] code);
        case (code)
            3'd1:    return 20;
            3'd2:    return 17;
            3'd3:    return 14;
            3'd4:    return 10;
            3'd5:    return 7;
            3'd6:    return 4;
            default: return 23;
        endcase
    endfunction

    function automatic int unsigned fmt_exp_bits(input logic [2:0] code);
        case (code)
            3'd1:    return 7;
            3'd2:    return 6;
            3'd3:    return 5;
            3'd4:    return 5;
            3'd5:    return 4;
            3'd6:    return 3;
            default: return 8;
        endcase
    endfunction

    function automatic logic [RANK_W-1:0] pop_slices(input logic [SLICES-1:0] m);
        logic [RANK_W-1:0] n;
        n = '0;
        for (int i = 0; i < int'(SLICES); i++) begin
            n = n + RANK_W'(m[i]);
        end
        return n;
    endfunction

endpackage

// File: rtl/wbsp_narrow.sv
module wbsp_narrow
    import wbsp_pkg::*;
(
    input  logic [WORD_W-1:0] src,
    input  logic [2:0]        fmt,
    output logic [WORD_W-1:0] narrow
);
    logic                 sgn;
    logic [SRC_EXP_W-1:0] exp_in;
    logic [SRC_MAN_W-1:0] frac_in;
    int unsigned          eb;
    int unsigned          mb;
    int                   rebiased;
    int                   exp_top;
    logic [WORD_W-1:0]    man_cut;
    logic [WORD_W-1:0]    exp_out;
    logic [WORD_W-1:0]    man_out;

    assign sgn     = src[WORD_W-1];
    assign exp_in  = src[WORD_W-2 -: SRC_EXP_W];
    assign frac_in = src[SRC_MAN_W-1:0];

    always_comb begin
        eb       = fmt_exp_bits(fmt);
        mb       = fmt_man_bits(fmt);
        exp_top  = (1 << eb) - 1;
        rebiased = int'({24'd0, exp_in}) - int'(SRC_BIAS) + ((1 << (eb - 1)) - 1);
        man_cut  = {9'd0, frac_in} >> (SRC_MAN_W - mb);
        exp_out  = '0;
        man_out  = '0;
        if (exp_in == SRC_EXP_W'(SRC_EXPMAX)) begin
            exp_out = WORD_W'(exp_top);
            if (frac_in != '0) begin
                man_out = man_cut | (WORD_W'(1) << (mb - 1));
            end
        end else if (exp_in == '0) begin
            exp_out = '0;
        end else if (rebiased >= exp_top) begin
            exp_out = WORD_W'(exp_top);
        end else if (rebiased > 0) begin
            exp_out = WORD_W'(rebiased);
            man_out = man_cut;
        end
        narrow = ({{(WORD_W-1){1'b0}}, sgn} << (eb + mb)) | (exp_out << mb) | man_out;
    end

endmodule

// File: rtl/wbsp_scatter.sv
module wbsp_scatter
    import wbsp_pkg::*;
(
    input  logic [WORD_W-1:0] src,
    input  logic [SLICES-1:0] mask,
    input  logic [RANK_W-1:0] base,
    output logic [WORD_W-1:0] word,
    output logic [SLICES-1:0] we
);
    always_comb begin
        int unsigned rank;
        rank = int'(base);
        word = '0;
        for (int s = 0; s < int'(SLICES); s++) begin
            if (mask[s]) begin
                if (rank < SLICES) begin
                    word[s*SLICE_W +: SLICE_W] = src[rank*SLICE_W +: SLICE_W];
                end
                rank = rank + 1;
            end
        end
        we = mask;
    end

endmodule

// File: rtl/wb_slice_packer.sv
module wb_slice_packer
    import wbsp_pkg::*;
#(
    parameter int unsigned PREG_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              in_is_float,
    input  logic [2:0]        in_fmt,
    input  logic [31:0]       in_value,
    input  logic [7:0]        in_mask0,
    input  logic [7:0]        in_mask1,
    input  logic [PREG_W-1:0] in_preg0,
    input  logic [PREG_W-1:0] in_preg1,
    output logic              out_valid,
    output logic [PREG_W-1:0] out_preg0,
    output logic [PREG_W-1:0] out_preg1,
    output logic [31:0]       out_word0,
    output logic [7:0]        out_we0,
    output logic [31:0]       out_word1,
    output logic [7:0]        out_we1
);
    localparam int unsigned PATHS = 2;

    logic [WORD_W-1:0] narrowed;
    logic              cv_valid;
    slice_set_t        cv_set;
    logic [PREG_W-1:0] cv_preg0;
    logic [PREG_W-1:0] cv_preg1;

    logic              pl_valid;
    slice_set_t        pl_set;
    logic [PREG_W-1:0] pl_preg0;
    logic [PREG_W-1:0] pl_preg1;

    logic [SLICES-1:0] path_mask [PATHS];
    logic [RANK_W-1:0] path_base [PATHS];
    logic [WORD_W-1:0] path_word [PATHS];
    logic [SLICES-1:0] path_we   [PATHS];

    wbsp_narrow u_narrow (
        .src    (in_value),
        .fmt    (in_fmt),
        .narrow (narrowed)
    );

    // Conversion stage: floats only.
    always_ff @(posedge clk) begin
        if (rst) begin
            cv_valid <= 1'b0;
            cv_set   <= '0;
            cv_preg0 <= '0;
            cv_preg1 <= '0;
        end else begin
            cv_valid <= in_valid && in_is_float;
            if (in_valid && in_is_float) begin
                cv_set   <= '{data: narrowed, mask0: in_mask0, mask1: in_mask1};
                cv_preg0 <= in_preg0;
                cv_preg1 <= in_preg1;
            end
        end
    end

    // Placement source: converted float has the slot, else a raw integer.
    always_comb begin
        if (cv_valid) begin
            pl_valid = 1'b1;
            pl_set   = cv_set;
            pl_preg0 = cv_preg0;
            pl_preg1 = cv_preg1;
        end else begin
            pl_valid = in_valid && !in_is_float;
            pl_set   = '{data: in_value, mask0: in_mask0, mask1: in_mask1};
            pl_preg0 = in_preg0;
            pl_preg1 = in_preg1;
        end
    end

    assign path_mask[0] = pl_set.mask0;
    assign path_mask[1] = pl_set.mask1;
    assign path_base[0] = '0;
    assign path_base[1] = pop_slices(pl_set.mask0);

    for (genvar g = 0; g < PATHS; g++) begin : g_path
        wbsp_scatter u_scatter (
            .src  (pl_set.data),
            .mask (path_mask[g]),
            .base (path_base[g]),
            .word (path_word[g]),
            .we   (path_we[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_preg0 <= '0;
            out_preg1 <= '0;
            out_word0 <= '0;
            out_we0   <= '0;
            out_word1 <= '0;
            out_we1   <= '0;
        end else begin
            out_valid <= pl_valid;
            out_preg0 <= pl_preg0;
            out_preg1 <= pl_preg1;
            out_word0 <= pl_valid ? path_word[0] : '0;
            out_we0   <= pl_valid ? path_we[0]   : '0;
            out_word1 <= pl_valid ? path_word[1] : '0;
            out_we1   <= pl_valid ? path_we[1]   : '0;
        end
    end

endmodule

// File: rtl/wbsp_checker.sv
module wbsp_checker #(
    parameter int unsigned PREG_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic              in_is_float,
    input logic [7:0]        in_mask0,
    input logic [7:0]        in_mask1,
    input logic [PREG_W-1:0] in_preg0,
    input logic [PREG_W-1:0] in_preg1,
    input logic              out_valid,
    input logic [PREG_W-1:0] out_preg0,
    input logic [PREG_W-1:0] out_preg1,
    input logic [31:0]       out_word0,
    input logic [7:0]        out_we0,
    input logic [31:0]       out_word1,
    input logic [7:0]        out_we1
);
    logic [31:0] keep0;
    logic [31:0] keep1;

    always_comb begin
        for (int s = 0; s < 8; s++) begin
            keep0[s*4 +: 4] = {4{out_we0[s]}};
            keep1[s*4 +: 4] = {4{out_we1[s]}};
        end
    end

    // R9
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (!out_valid && out_we0 == 8'h00 && out_we1 == 8'h00));

    // R2
    unmasked_zero_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ((out_word0 & ~keep0) == 32'h0 && (out_word1 & ~keep1) == 32'h0));

    // R2
    idle_enable_chk: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> (out_we0 == 8'h00 && out_we1 == 8'h00));

    // R2
    int_enable_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_is_float) |=> (out_we0 == $past(in_mask0) && out_we1 == $past(in_mask1)));

    // R3
    int_latency_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_is_float) |=> out_valid);

    // R3
    float_latency_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_is_float) |=> ##1 out_valid);

    // R3
    no_spurious_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ($past(in_valid && !in_is_float) || $past(in_valid && in_is_float, 2)));

    // R10
    int_preg_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_is_float) |=> (out_preg0 == $past(in_preg0) && out_preg1 == $past(in_preg1)));

    // R12
    spacing_rule_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_is_float) |=> !(in_valid && !in_is_float));

endmodule

bind wb_slice_packer wbsp_checker #(.PREG_W(PREG_W)) u_wbsp_checker (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .in_is_float (in_is_float),
    .in_mask0    (in_mask0),
    .in_mask1    (in_mask1),
    .in_preg0    (in_preg0),
    .in_preg1    (in_preg1),
    .out_valid   (out_valid),
    .out_preg0   (out_preg0),
    .out_preg1   (out_preg1),
    .out_word0   (out_word0),
    .out_we0     (out_we0),
    .out_word1   (out_word1),
    .out_we1     (out_we1)
);

// File: tb/tb_wb_slice_packer.sv
module tb_wb_slice_packer;
    localparam int CLK_PERIOD = 10;
    localparam int PREG_W     = 8;
    localparam int WATCHDOG   = 5000;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              in_valid = 1'b0;
    logic              in_is_float = 1'b0;
    logic [2:0]        in_fmt = '0;
    logic [31:0]       in_value = '0;
    logic [7:0]        in_mask0 = '0;
    logic [7:0]        in_mask1 = '0;
    logic [PREG_W-1:0] in_preg0 = '0;
    logic [PREG_W-1:0] in_preg1 = '0;
    logic              out_valid;
    logic [PREG_W-1:0] out_preg0;
    logic [PREG_W-1:0] out_preg1;
    logic [31:0]       out_word0;
    logic [7:0]        out_we0;
    logic [31:0]       out_word1;
    logic [7:0]        out_we1;

    typedef struct {
        logic [31:0]       val;
        int                nibs;
        logic [7:0]        m0;
        logic [7:0]        m1;
        logic [PREG_W-1:0] p0;
        logic [PREG_W-1:0] p1;
        int                due;
        string             tag;
    } exp_t;

    exp_t expq[$];
    int   cyc = 0;
    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    wb_slice_packer #(.PREG_W(PREG_W)) dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_is_float(in_is_float),
        .in_fmt(in_fmt), .in_value(in_value), .in_mask0(in_mask0), .in_mask1(in_mask1),
        .in_preg0(in_preg0), .in_preg1(in_preg1), .out_valid(out_valid),
        .out_preg0(out_preg0), .out_preg1(out_preg1), .out_word0(out_word0),
        .out_we0(out_we0), .out_word1(out_word1), .out_we1(out_we1)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h (cycle %0d)", tag, act, expv, cyc);
        end
    endtask

    function automatic int nib_count(input logic [2:0] f);
        case (f)
            3'd1: return 7;  3'd2: return 6;  3'd3: return 5;
            3'd4: return 4;  3'd5: return 3;  3'd6: return 2;
            default: return 8;
        endcase
    endfunction

    // Driver: present one item and queue what the requirements predict.
    task automatic send(input bit isf, input logic [2:0] f, input logic [31:0] v,
                        input logic [7:0] m0, input logic [7:0] m1,
                        input logic [31:0] expv, input string tag);
        exp_t e;
        @(negedge clk);
        in_valid    = 1'b1;
        in_is_float = isf;
        in_fmt      = f;
        in_value    = v;
        in_mask0    = m0;
        in_mask1    = m1;
        in_preg0    = PREG_W'(8'h10 + expq.size());
        in_preg1    = PREG_W'(8'hA0 + cyc);
        e.val  = expv;
        e.nibs = isf ? nib_count(f) : 8;
        e.m0   = m0;
        e.m1   = m1;
        e.p0   = in_preg0;
        e.p1   = in_preg1;
        e.due  = cyc + (isf ? 2 : 1);
        e.tag  = tag;
        expq.push_back(e);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    // Monitor: gather the slices back and compare with the front of the queue.
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (out_valid) begin
                if (expq.size() == 0) begin
                    check(1'b0, "R3 unexpected output", 32'h1, 32'h0);
                end else begin
                    exp_t e;
                    logic [31:0] got;
                    logic [31:0] want;
                    logic [31:0] extra;
                    logic [31:0] hole0;
                    logic [31:0] hole1;
                    int k;
                    e = expq.pop_front();
                    got = '0; extra = '0; hole0 = '0; hole1 = '0; k = 0;
                    for (int s = 0; s < 8; s++) begin
                        if (out_we0[s]) begin
                            if (k < 8) got[k*4 +: 4] = out_word0[s*4 +: 4];
                            else extra[s*4 +: 4] = out_word0[s*4 +: 4];
                            k++;
                        end else hole0[s*4 +: 4] = out_word0[s*4 +: 4];
                    end
                    for (int s = 0; s < 8; s++) begin
                        if (out_we1[s]) begin
                            if (k < 8) got[k*4 +: 4] = out_word1[s*4 +: 4];
                            else extra[s*4 +: 4] = out_word1[s*4 +: 4];
                            k++;
                        end else hole1[s*4 +: 4] = out_word1[s*4 +: 4];
                    end
                    want = '0;
                    for (int n = 0; n < 8; n++) begin
                        if (n < e.nibs && n < k) want[n*4 +: 4] = e.val[n*4 +: 4];
                    end
                    check(cyc == e.due, {"R3 latency ", e.tag}, 32'(cyc), 32'(e.due));
                    check(got == want, {"R1/R4 value ", e.tag}, got, want);
                    check(out_we0 == e.m0 && out_we1 == e.m1, {"R2 enables ", e.tag},
                          {16'h0, out_we0, out_we1}, {16'h0, e.m0, e.m1});
                    check(hole0 == 0 && hole1 == 0, {"R2 unmasked zero ", e.tag}, hole0 | hole1, 32'h0);
                    check(extra == 0, {"R8 overflow slices ", e.tag}, extra, 32'h0);
                    check(out_preg0 == e.p0 && out_preg1 == e.p1, {"R10 regs ", e.tag},
                          {16'h0, 8'(out_preg0), 8'(out_preg1)}, {16'h0, 8'(e.p0), 8'(e.p1)});
                end
            end else if (expq.size() != 0 && expq[0].due <= cyc) begin
                check(1'b0, {"R3 missing output ", expq[0].tag}, 32'h0, 32'h1);
                void'(expq.pop_front());
            end
        end
    end

    task automatic finish_run();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=expired expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9 reset state
        check(!out_valid && out_we0 == 0 && out_we1 == 0, "R9 reset quiet",
              {23'h0, out_valid, out_we0}, 32'h0);
        @(negedge clk);
        rst = 1'b0;
        idle(2);
        check(!out_valid && out_we0 == 0 && out_we1 == 0, "R9 idle after reset",
              {23'h0, out_valid, out_we0}, 32'h0);

        // R1 R11 integers, back to back
        send(0, 3'd6, 32'h12345678, 8'hFF, 8'h00, 32'h12345678, "R11 full mask0");
        send(0, 3'd4, 32'h12345678, 8'h0F, 8'hF0, 32'h12345678, "R1 split 4/4");
        send(0, 3'd0, 32'hDEADBEEF, 8'hA5, 8'h5A, 32'hDEADBEEF, "R1 interleaved");
        send(0, 3'd0, 32'hCAFEF00D, 8'hFF, 8'h03, 32'hCAFEF00D, "R8 ten slices");
        send(0, 3'd0, 32'h0000_00F3, 8'h80, 8'h01, 32'h000000F3, "R1 two nibbles");
        idle(3);

        // R4 formats, normal values
        send(1, 3'd4, 32'h3F800000, 8'h80, 8'h4C, 32'h00003C00, "R4 fmt16 one split");
        idle(1);
        send(1, 3'd6, 32'h3F800000, 8'h03, 8'h00, 32'h00000030, "R4 fmt8 one");
        idle(1);
        send(1, 3'd2, 32'h3F800000, 8'h3F, 8'h00, 32'h003E0000, "R4 fmt24 one");
        idle(1);
        send(1, 3'd1, 32'h3F800000, 8'h7F, 8'h00, 32'h03F00000, "R4 fmt28 one");
        idle(1);
        send(1, 3'd3, 32'h3F800000, 8'h07, 8'h18, 32'h0003C000, "R4 fmt20 one");
        idle(1);
        send(1, 3'd4, 32'hC0200000, 8'h0F, 8'h00, 32'h0000C100, "R4 fmt16 neg");
        idle(1);
        send(1, 3'd5, 32'hC0200000, 8'h70, 8'h00, 32'h00000C20, "R4 fmt12 neg");
        idle(1);
        send(1, 3'd0, 32'h40490FDB, 8'hF0, 8'h0F, 32'h40490FDB, "R4 fmt32 identity");
        idle(1);
        send(1, 3'd4, 32'h3FFFFFFF, 8'h0F, 8'h00, 32'h00003FFF, "R4 truncate no round");
        idle(1);
        send(1, 3'd4, 32'h477FE000, 8'h0F, 8'h00, 32'h00007BFF, "R4 fmt16 max finite");
        idle(1);
        send(1, 3'd4, 32'h38800000, 8'h0F, 8'h00, 32'h00000400, "R4 fmt16 min normal");
        idle(1);

        // R5 overflow
        send(1, 3'd4, 32'h47800000, 8'h0F, 8'h00, 32'h00007C00, "R5 fmt16 overflow");
        idle(1);
        send(1, 3'd6, 32'hC9742400, 8'h30, 8'h00, 32'h000000F0, "R5 fmt8 neg overflow");
        idle(1);

        // R6 underflow and denormal
        send(1, 3'd4, 32'h38000000, 8'h0F, 8'h00, 32'h00000000, "R6 fmt16 underflow");
        idle(1);
        send(1, 3'd4, 32'h80000001, 8'hF0, 8'h00, 32'h00008000, "R6 neg denormal");
        idle(1);

        // R7 specials
        send(1, 3'd6, 32'h7FC00000, 8'h81, 8'h00, 32'h00000078, "R7 quiet nan");
        idle(1);
        send(1, 3'd6, 32'h7F800001, 8'h81, 8'h00, 32'h00000078, "R7 low nan forced");
        idle(1);
        send(1, 3'd4, 32'hFF800000, 8'h03, 8'h03, 32'h0000FC00, "R7 neg inf");
        idle(1);

        // R3 mixed stream: int, float, gap, int
        send(0, 3'd0, 32'h89ABCDEF, 8'hFF, 8'h00, 32'h89ABCDEF, "R3 mix int a");
        send(1, 3'd4, 32'h3F800000, 8'hC0, 8'h03, 32'h00003C00, "R3 mix float");
        idle(1);
        send(0, 3'd0, 32'h01234567, 8'h0F, 8'hF0, 32'h01234567, "R3 mix int b");
        idle(4);

        check(expq.size() == 0, "R3 all items delivered", 32'(expq.size()), 32'h0);
        finish_run();
    end

endmodule